// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Masking

This block sits between a set of device interrupt request lines and a CPU. Devices hold their request line high until they are serviced. A separate non-maskable request line carries fatal events such as a memory fault or a supply-loss warning. Each cycle the controller works out which of these requests may compete. It picks one winner through a priority selector and raises a single registered interrupt flag together with the winner's identifier.

The CPU sets up the controller through a small write-only register port. It can write a global enable, one mask bit per line, and a per-line priority level table that remaps the order in which lines win. Once the flag is up, the flag and the identifier stay frozen until the CPU pulses the acknowledge input. A build parameter can drop the level table, in which case each line's level is fixed at its own index.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While the flag is low, an eligible pending request present before a rising clock edge makes `irq_o` high right after that edge (one register stage). A maskable line is eligible when the global enable is 1 and its mask bit is 0.
- R2: `irq_id_o` carries the winning line index (0 to NUM_LINES-1) whenever `irq_o` is high. A non-maskable win is reported as the value NUM_LINES.
- R3: The global enable is bit 0 of the word written to address 0. While it is 0, no maskable line can raise the flag.
- R4: The mask word at address 1 holds one bit per line, with bit i for line i. A 1 blocks that line and a 0 lets it compete.
- R5: `nmi_i` raises the flag whatever the global enable and the masks are, and it wins over every maskable line whatever their levels.
- R6: Among eligible lines, the line with the largest level wins. The level for line i is held at address 2+i in data bits [LVL_W-1:0], where LVL_W = clog2(NUM_LINES).
- R7: When two eligible lines have equal levels, the lower line index wins.
- R8: While `irq_o` is high, `irq_o` and `irq_id_o` do not change until `ack_i` is sampled high. The flag then drops after that edge, and arbitration resumes on the following edge.
- R9: After reset, `irq_o` and `irq_id_o` are 0, every line is masked, the global enable is 0, and the level of line i equals i.
- R10: With no request on any line and `nmi_i` low, an idle controller keeps `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| req_i | input | NUM_LINES | Level-sensitive device requests, one bit per line |
| nmi_i | input | 1 | Non-maskable request |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address: 0 enable, 1 mask, 2+i level of line i |
| wr_data_i | input | DATA_W | Register write data |
| ack_i | input | 1 | CPU acknowledge of the current interrupt |
| irq_o | output | 1 | Registered interrupt flag to the CPU |
| irq_id_o | output | ID_W | Registered identifier of the winning device |

## Verification
A register write takes effect at the edge where the strobe is sampled. A request that is present while the controller is idle shows up on `irq_o` and `irq_id_o` one edge later. An acknowledge clears the flag at the edge where it is sampled, and a request that is still pending comes back one edge after that. The bench drives every input and reads every output one time unit after a rising edge. Each check is placed exactly that many edges after its stimulus. The hold test checks the frozen identifier on several consecutive cycles before it sends the acknowledge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   // Register addresses; the level table starts at LVL_BASE and runs one entry per line.
   localparam int unsigned ADDR_ENABLE = 0;
   localparam int unsigned ADDR_MASK   = 1;
   localparam int unsigned LVL_BASE    = 2;
endpackage

// File: rtl/irqc_cfg.sv
module irqc_cfg
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned LVL_W     = 3,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 32,
   parameter bit          REMAP_EN  = 1'b1
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       wr_en_i,
   input  logic [ADDR_W-1:0]          wr_addr_i,
   input  logic [DATA_W-1:0]          wr_data_i,
   output logic                       gen_en_o,
   output logic [NUM_LINES-1:0]       mask_o,
   output logic [NUM_LINES*LVL_W-1:0] lvl_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gen_en_o <= 1'b0;
         mask_o   <= '1;
      end else if (wr_en_i) begin
         if (wr_addr_i == ADDR_W'(ADDR_ENABLE)) gen_en_o <= wr_data_i[0];
         if (wr_addr_i == ADDR_W'(ADDR_MASK))   mask_o   <= wr_data_i[NUM_LINES-1:0];
      end
   end

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_lvl
      if (REMAP_EN) begin : g_table
         logic [LVL_W-1:0] lvl_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
               lvl_q <= LVL_W'(g);
            else if (wr_en_i && wr_addr_i == ADDR_W'(LVL_BASE + g))
               lvl_q <= wr_data_i[LVL_W-1:0];
         end
         assign lvl_o[g*LVL_W +: LVL_W] = lvl_q;
      end else begin : g_fixed
         assign lvl_o[g*LVL_W +: LVL_W] = LVL_W'(g);
      end
   end
endmodule

// File: rtl/irqc_select.sv
module irqc_select #(
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned LVL_W     = 3,
   parameter int unsigned ID_W      = 4
) (
   input  logic [NUM_LINES-1:0]       elig_i,
   input  logic [NUM_LINES*LVL_W-1:0] lvl_i,
   input  logic                       nmi_i,
   output logic                       any_o,
   output logic [ID_W-1:0]            win_o
);
   logic             found;
   logic [LVL_W-1:0] best;

   always_comb begin
      found = 1'b0;
      best  = '0;
      win_o = '0;
      // Strict greater-than keeps the lower index on equal levels.
      for (int i = 0; i < NUM_LINES; i++) begin
         if (elig_i[i] && (!found || lvl_i[i*LVL_W +: LVL_W] > best)) begin
            found = 1'b1;
            best  = lvl_i[i*LVL_W +: LVL_W];
            win_o = ID_W'(i);
         end
      end
      if (nmi_i) win_o = ID_W'(NUM_LINES);
      any_o = found | nmi_i;
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter  int unsigned NUM_LINES = 8,
   parameter  int unsigned DATA_W    = 32,
   parameter  bit          REMAP_EN  = 1'b1,
   localparam int unsigned LVL_W     = $clog2(NUM_LINES),
   localparam int unsigned ID_W      = $clog2(NUM_LINES + 1),
   localparam int unsigned ADDR_W    = $clog2(NUM_LINES + 2)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [NUM_LINES-1:0] req_i,
   input  logic                 nmi_i,
   input  logic                 wr_en_i,
   input  logic [ADDR_W-1:0]    wr_addr_i,
   input  logic [DATA_W-1:0]    wr_data_i,
   input  logic                 ack_i,
   output logic                 irq_o,
   output logic [ID_W-1:0]      irq_id_o
);
   if (NUM_LINES < 2) begin : g_chk_lines
      $error("prio_irq_ctrl: NUM_LINES must be at least 2");
   end
   if (DATA_W < NUM_LINES) begin : g_chk_data
      $error("prio_irq_ctrl: DATA_W must hold one mask bit per line");
   end

   logic                       gen_en;
   logic [NUM_LINES-1:0]       mask;
   logic [NUM_LINES*LVL_W-1:0] lvl;
   logic [NUM_LINES-1:0]       elig;
   logic                       any;
   logic [ID_W-1:0]            win;

   irqc_cfg #(
      .NUM_LINES(NUM_LINES), .LVL_W(LVL_W), .ADDR_W(ADDR_W),
      .DATA_W(DATA_W), .REMAP_EN(REMAP_EN)
   ) u_cfg (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
      .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .gen_en_o(gen_en), .mask_o(mask), .lvl_o(lvl)
   );

   assign elig = req_i & ~mask & {NUM_LINES{gen_en}};

   irqc_select #(
      .NUM_LINES(NUM_LINES), .LVL_W(LVL_W), .ID_W(ID_W)
   ) u_sel (
      .elig_i(elig), .lvl_i(lvl), .nmi_i(nmi_i), .any_o(any), .win_o(win)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         irq_o    <= 1'b0;
         irq_id_o <= '0;
      end else if (irq_o) begin
         if (ack_i) irq_o <= 1'b0;
      end else if (any) begin
         irq_o    <= 1'b1;
         irq_id_o <= win;
      end
   end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned ID_W      = 4
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic [NUM_LINES-1:0] req_i,
   input logic                 nmi_i,
   input logic                 ack_i,
   input logic                 irq_o,
   input logic [ID_W-1:0]      irq_id_o
);
   AST_HOLD_UNTIL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o && !ack_i |=> irq_o && $stable(irq_id_o)); // R8
   AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o && ack_i |=> !irq_o); // R8
   AST_NMI_TAKES_OVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_o && nmi_i |=> irq_o && irq_id_o == ID_W'(NUM_LINES)); // R5
   AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_o && !nmi_i && req_i == '0 |=> !irq_o); // R10
   AST_ID_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> irq_id_o <= ID_W'(NUM_LINES)); // R2
endmodule

bind prio_irq_ctrl irqc_checker #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_irqc_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .nmi_i(nmi_i),
   .ack_i(ack_i), .irq_o(irq_o), .irq_id_o(irq_id_o)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
   localparam int N = 8;
   localparam int IDW = 4;
   localparam int AW = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   req = '0;
   logic           nmi = 1'b0;
   logic           wr_en = 1'b0;
   logic [AW-1:0]  wr_addr = '0;
   logic [31:0]    wr_data = '0;
   logic           ack = 1'b0;
   logic           irq;
   logic [IDW-1:0] irq_id;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   prio_irq_ctrl uut (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .nmi_i(nmi),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .ack_i(ack), .irq_o(irq), .irq_id_o(irq_id)
   );

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic check(string tag, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(int addr, int data);
      wr_en = 1'b1; wr_addr = AW'(addr); wr_data = 32'(data);
      cyc();
      wr_en = 1'b0;
   endtask

   task automatic ack_and_clear();
      req = '0; nmi = 1'b0; ack = 1'b1;
      cyc();
      check("R8 flag drops on ack", int'(irq), 0);
      ack = 1'b0;
      cyc();
      check("R10 idle stays low", int'(irq), 0);
   endtask

   task automatic t_reset();
      check("R9 reset flag", int'(irq), 0);
      check("R9 reset id", int'(irq_id), 0);
      req = '1;
      cyc(); cyc();
      check("R9 R3 lines masked and disabled at reset", int'(irq), 0);
      wr(0, 1);
      cyc();
      check("R9 R4 still masked after enable", int'(irq), 0);
      wr(1, 0);
      cyc();
      check("R1 flag after unmask", int'(irq), 1);
      check("R2 R9 identity levels pick line 7", int'(irq_id), 7);
      ack_and_clear();
   endtask

   task automatic t_mask();
      wr(1, 32'h80);
      req = '1;
      cyc();
      check("R4 masked line 7 skipped", int'(irq_id), 6);
      ack_and_clear();
      wr(1, 0);
   endtask

   task automatic t_levels();
      wr(2 + 2, 7);
      req = N'((1 << 2) | (1 << 5));
      cyc();
      check("R6 remapped line 2 beats line 5", int'(irq_id), 2);
      ack_and_clear();
      req = N'((1 << 2) | (1 << 7));
      cyc();
      check("R7 equal levels lower index", int'(irq_id), 2);
      ack_and_clear();
      wr(2 + 2, 2);
   endtask

   task automatic t_global();
      wr(0, 0);
      req = '1;
      for (int k = 0; k < 3; k++) begin
         cyc();
         check("R3 global enable off", int'(irq), 0);
      end
      req = '0;
      wr(0, 1);
   endtask

   task automatic t_nmi();
      wr(0, 0);
      wr(1, 32'hFF);
      nmi = 1'b1;
      cyc();
      check("R5 nmi ignores masks flag", int'(irq), 1);
      check("R5 nmi id", int'(irq_id), N);
      ack_and_clear();
      wr(0, 1);
      wr(1, 0);
      req = '1; nmi = 1'b1;
      cyc();
      check("R5 nmi beats lines", int'(irq_id), N);
      ack_and_clear();
   endtask

   task automatic t_hold();
      req = N'(1 << 3);
      cyc();
      check("R1 single line flag", int'(irq), 1);
      check("R2 single line id", int'(irq_id), 3);
      req = N'((1 << 3) | (1 << 7));
      for (int k = 0; k < 3; k++) begin
         cyc();
         check("R8 flag held", int'(irq), 1);
         check("R8 id held", int'(irq_id), 3);
      end
      ack = 1'b1;
      cyc();
      check("R8 drop after ack", int'(irq), 0);
      ack = 1'b0;
      cyc();
      check("R8 rearbitrate flag", int'(irq), 1);
      check("R8 rearbitrate id", int'(irq_id), 7);
      ack_and_clear();
   endtask

   task automatic t_quiet();
      req = '0; nmi = 1'b0;
      for (int k = 0; k < 2; k++) begin
         cyc();
         check("R10 no requests", int'(irq), 0);
      end
   endtask

   initial begin
      cyc(); cyc();
      rst_n = 1'b1;
      cyc();
      t_reset();
      t_mask();
      t_levels();
      t_global();
      t_nmi();
      t_hold();
      t_quiet();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule